// File: doc/BRIEF.md
# Interrupt Priority Byte Store with Security-Qualified View

This block keeps one 8-bit priority value for each interrupt ID and serves reads and writes to it. An access names an interrupt by a byte offset equal to its ID and moves either one byte or a 32-bit word. A word covers four consecutive IDs, with the lowest-numbered ID in bits [7:0]. IDs below the first shared interrupt and IDs at or beyond the implemented count are not backed by storage.

Every access carries a secure attribute. A non-secure access is restricted only while the security-disable input is low. Under that restriction, the group bitmap decides what the access can see. An ID whose group bit is 0 is secure: it reads as zero and cannot be written. An ID whose group bit is 1 is non-secure, and the access sees its priority on a compressed scale. On a read the stored value is shifted left by one. On a write the value is shifted right by one and the top bit is forced to 1, so a non-secure agent can only place priorities in the lower-urgency half of the range.

The full priority array is presented in parallel to downstream arbitration logic. A one-cycle update strobe reports the ID range of every write that changes storage.

Top module: `prio_store_top`

## Requirements
- R1: After reset every stored priority is 0x00, and the update strobe and read-valid outputs are low.
- R2: A byte access with reqSecure=1 writes the given byte unchanged, or reads the stored byte unchanged. rdData and rdValid appear in the cycle after the request, with the read byte in bits [7:0] and the upper bytes zero.
- R3: With reqSecure=0 and secDisable=0, an ID whose groupBits bit is 0 reads as 0x00, and a write to it leaves its stored value unchanged.
- R4: With reqSecure=0 and secDisable=0, a read of an ID whose groupBits bit is 1 returns (stored << 1) truncated to 8 bits.
- R5: With reqSecure=0 and secDisable=0, a write to an ID whose groupBits bit is 1 stores 0x80 | (value >> 1).
- R6: A word access (reqWord=1) at address A covers IDs A to A+3. ID A+k uses bits [8k+7:8k], and each lane follows the byte rules for its own ID.
- R7: A word write is dropped in full when A is below FIRST_SHARED or A+3 is at or above NUM_IDS.
- R8: A byte access to an ID below FIRST_SHARED or at or above NUM_IDS reads 0x00, and a byte write to such an ID changes nothing.
- R9: A write that stores at least one byte raises updStrobe for exactly one cycle, in the cycle after the request. It presents updFirst = A and updCount = 1 for a byte write or 4 for a word write. A write that stores nothing, or a read, raises no strobe.
- R10: While secDisable=1, a non-secure access behaves exactly like a secure one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 32-bit word, 0 = byte |
| reqAddr | input | ADDR_W | Byte offset, equal to the first interrupt ID |
| reqWdata | input | 32 | Write data, lowest ID in bits [7:0] |
| reqSecure | input | 1 | Access attribute, 1 = secure |
| secDisable | input | 1 | 1 = single security state; all accesses are full-view |
| groupBits | input | NUM_IDS | Per-ID group, 1 = non-secure |
| rdData | output | 32 | Read result, held until the next read |
| rdValid | output | 1 | rdData updated this cycle |
| updStrobe | output | 1 | One-cycle pulse after a write that stored data |
| updFirst | output | ADDR_W | First ID of the updated range |
| updCount | output | 3 | Number of IDs in the updated range (1 or 4) |
| prioFlat | output | 8*NUM_IDS | All stored priorities, ID i in bits [8i+7:8i] |

## Verification
Several properties are checked on every cycle. The strobe and read-valid pulses are checked against the request one cycle earlier, and the strobe is checked to be absent after a word write with an illegal range. The range below the first shared ID is checked to stay frozen. Out-of-range byte reads are checked to return zero, and every non-secure byte write that lands is checked to leave the top bit of the stored byte set. The exact values of the shifted views, the lane placement within words, the silent drop of writes to secure IDs and the equivalence under security-disable are all value relations. Only the bench's sweeps over every address, against a model of the whole array, show those.

// File: rtl/prio_store_pkg.sv
package prio_store_pkg;

  // Strobes from the access decoder to the storage datapath.
  typedef struct packed {
    logic [3:0] laneWe;   // lane k writes ID addr+k
    logic [3:0] laneRd;   // lane k returns data (else zero)
    logic       nsView;   // apply the compressed non-secure scale
    logic       rdEn;     // capture a read result
    logic       upd;      // at least one lane writes
    logic       word;     // 32-bit access
  } prio_ctrl_t;

endpackage

// File: rtl/prio_store_ctrl.sv
module prio_store_ctrl
  import prio_store_pkg::*;
#(
  parameter int NUM_IDS      = 64,
  parameter int FIRST_SHARED = 32,
  parameter int ADDR_W       = 8
) (
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic               reqWord,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqSecure,
  input  logic               secDisable,
  input  logic [NUM_IDS-1:0] groupBits,
  output prio_ctrl_t         ctrl
);
  localparam int LID_W = ADDR_W + 2;

  logic              nsView;
  logic              wordOk;
  logic [LID_W-1:0]  laneId [4];
  logic [3:0]        inRange;
  logic [3:0]        laneGrp;
  logic [3:0]        laneOn;

  assign nsView = !reqSecure && !secDisable;

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      laneId[l]  = LID_W'(reqAddr) + LID_W'(l);
      inRange[l] = (laneId[l] >= LID_W'(FIRST_SHARED)) &&
                   (laneId[l] <  LID_W'(NUM_IDS));
      laneOn[l]  = (l == 0) || reqWord;
      laneGrp[l] = 1'b0;
      for (int i = 0; i < NUM_IDS; i++) begin
        if (laneId[l] == LID_W'(i)) laneGrp[l] = groupBits[i];
      end
    end
  end

  // Word writes are accepted only when all four IDs are implemented.
  assign wordOk = inRange[0] && inRange[3];

  always_comb begin
    ctrl = '0;
    ctrl.nsView = nsView;
    ctrl.word   = reqWord;
    ctrl.rdEn   = reqValid && !reqWrite;
    for (int l = 0; l < 4; l++) begin
      ctrl.laneRd[l] = laneOn[l] && inRange[l] && (!nsView || laneGrp[l]);
      ctrl.laneWe[l] = reqValid && reqWrite && ctrl.laneRd[l] &&
                       (!reqWord || wordOk);
    end
    ctrl.upd = |ctrl.laneWe;
  end
endmodule

// File: rtl/prio_store_dp.sv
module prio_store_dp
  import prio_store_pkg::*;
#(
  parameter int NUM_IDS   = 64,
  parameter int ADDR_W    = 8,
  parameter logic [7:0] RESET_PRIO = 8'h00
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  prio_ctrl_t           ctrl,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [31:0]          reqWdata,
  output logic [31:0]          rdData,
  output logic                 rdValid,
  output logic                 updStrobe,
  output logic [ADDR_W-1:0]    updFirst,
  output logic [2:0]           updCount,
  output logic [8*NUM_IDS-1:0] prioFlat
);
  localparam int LID_W = ADDR_W + 2;

  logic [7:0]       prio    [NUM_IDS];
  logic [LID_W-1:0] laneId  [4];
  logic [7:0]       wrByte  [4];
  logic [7:0]       curByte [4];
  logic [31:0]      rdWord;

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      laneId[l] = LID_W'(reqAddr) + LID_W'(l);
      wrByte[l] = ctrl.nsView ? {1'b1, reqWdata[8*l+1 +: 7]}
                              : reqWdata[8*l +: 8];
      curByte[l] = 8'h00;
      for (int i = 0; i < NUM_IDS; i++) begin
        if (laneId[l] == LID_W'(i)) curByte[l] = prio[i];
      end
      if (!ctrl.laneRd[l])      rdWord[8*l +: 8] = 8'h00;
      else if (ctrl.nsView)     rdWord[8*l +: 8] = {curByte[l][6:0], 1'b0};
      else                      rdWord[8*l +: 8] = curByte[l];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_IDS; i++) prio[i] <= RESET_PRIO;
    end else begin
      for (int i = 0; i < NUM_IDS; i++) begin
        for (int l = 0; l < 4; l++) begin
          if (ctrl.laneWe[l] && laneId[l] == LID_W'(i)) prio[i] <= wrByte[l];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      rdValid   <= 1'b0;
      updStrobe <= 1'b0;
      updFirst  <= '0;
      updCount  <= '0;
    end else begin
      rdValid   <= ctrl.rdEn;
      updStrobe <= ctrl.upd;
      if (ctrl.rdEn) rdData <= rdWord;
      if (ctrl.upd) begin
        updFirst <= reqAddr;
        updCount <= ctrl.word ? 3'd4 : 3'd1;
      end
    end
  end

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_flat
    assign prioFlat[8*g +: 8] = prio[g];
  end
endmodule

// File: rtl/prio_store_top.sv
module prio_store_top
  import prio_store_pkg::*;
#(
  parameter int NUM_IDS      = 64,
  parameter int FIRST_SHARED = 32,
  parameter int ADDR_W       = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqWord,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [31:0]          reqWdata,
  input  logic                 reqSecure,
  input  logic                 secDisable,
  input  logic [NUM_IDS-1:0]   groupBits,
  output logic [31:0]          rdData,
  output logic                 rdValid,
  output logic                 updStrobe,
  output logic [ADDR_W-1:0]    updFirst,
  output logic [2:0]           updCount,
  output logic [8*NUM_IDS-1:0] prioFlat
);
  prio_ctrl_t ctrl;

  prio_store_ctrl #(
    .NUM_IDS(NUM_IDS), .FIRST_SHARED(FIRST_SHARED), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqWord(reqWord),
    .reqAddr(reqAddr), .reqSecure(reqSecure), .secDisable(secDisable),
    .groupBits(groupBits), .ctrl(ctrl)
  );

  prio_store_dp #(
    .NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W), .RESET_PRIO(8'h00)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rdData(rdData), .rdValid(rdValid),
    .updStrobe(updStrobe), .updFirst(updFirst), .updCount(updCount),
    .prioFlat(prioFlat)
  );
endmodule

// File: rtl/prio_store_chk.sv
module prio_store_chk #(
  parameter int NUM_IDS      = 64,
  parameter int FIRST_SHARED = 32,
  parameter int ADDR_W       = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqWrite,
  input logic                 reqWord,
  input logic [ADDR_W-1:0]    reqAddr,
  input logic                 reqSecure,
  input logic                 secDisable,
  input logic [NUM_IDS-1:0]   groupBits,
  input logic [31:0]          rdData,
  input logic                 rdValid,
  input logic                 updStrobe,
  input logic [2:0]           updCount,
  input logic [8*NUM_IDS-1:0] prioFlat
);
  logic inRangeB;
  logic grpB;
  logic nsWrSeen;
  logic [ADDR_W-1:0] nsIdx;
  logic msbAtIdx;

  assign inRangeB = (int'(reqAddr) >= FIRST_SHARED) && (int'(reqAddr) < NUM_IDS);

  always_comb begin
    grpB = 1'b0;
    msbAtIdx = 1'b0;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (int'(reqAddr) == i) grpB = groupBits[i];
      if (int'(nsIdx) == i)   msbAtIdx = prioFlat[8*i+7];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nsWrSeen <= 1'b0;
      nsIdx    <= '0;
    end else begin
      nsWrSeen <= reqValid && reqWrite && !reqWord && !reqSecure &&
                  !secDisable && inRangeB && grpB;
      nsIdx    <= reqAddr;
    end
  end

  a_r9_strobe_after_write: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |-> $past(reqValid && reqWrite));

  a_r9_count_legal: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |-> (updCount == 3'd1 || updCount == 3'd4));

  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rdValid);

  a_r2_valid_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(reqValid && !reqWrite));

  a_r7_bad_word_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqWord &&
     (int'(reqAddr) < FIRST_SHARED || int'(reqAddr) + 3 >= NUM_IDS))
    |=> !updStrobe);

  a_r8_oob_byte_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !reqWord && !inRangeB) |=> (rdData == 32'h0));

  a_r5_ns_write_top_bit: assert property (@(posedge clk) disable iff (!rstN)
    nsWrSeen |-> msbAtIdx);

  if (FIRST_SHARED > 0) begin : g_low
    a_r8_low_ids_frozen: assert property (@(posedge clk) disable iff (!rstN)
      $stable(prioFlat[8*FIRST_SHARED-1:0]));
  end
endmodule

bind prio_store_top prio_store_chk #(
  .NUM_IDS(NUM_IDS), .FIRST_SHARED(FIRST_SHARED), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqWord(reqWord), .reqAddr(reqAddr), .reqSecure(reqSecure),
  .secDisable(secDisable), .groupBits(groupBits), .rdData(rdData),
  .rdValid(rdValid), .updStrobe(updStrobe), .updCount(updCount),
  .prioFlat(prioFlat)
);

// File: tb/prio_store_top_bench.sv
module prio_store_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IDS = 48;
  localparam int FIRST_SHARED = 32;
  localparam int ADDR_W = 6;
  localparam int SPAN = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic reqSecure = 1'b1, secDisable = 1'b0;
  logic [NUM_IDS-1:0] groupBits = '0;
  logic [31:0] rdData;
  logic rdValid, updStrobe;
  logic [ADDR_W-1:0] updFirst;
  logic [2:0] updCount;
  logic [8*NUM_IDS-1:0] prioFlat;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [NUM_IDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_store_top #(.NUM_IDS(NUM_IDS), .FIRST_SHARED(FIRST_SHARED), .ADDR_W(ADDR_W))
  u_prio_store_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqSecure(reqSecure), .secDisable(secDisable), .groupBits(groupBits),
    .rdData(rdData), .rdValid(rdValid), .updStrobe(updStrobe),
    .updFirst(updFirst), .updCount(updCount), .prioFlat(prioFlat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit idOk(input int id);
    return id >= FIRST_SHARED && id < NUM_IDS;
  endfunction

  function automatic bit visible(input int id, input bit sec, input bit dis);
    return sec || dis || groupBits[id];
  endfunction

  // One access: drive after a falling edge, sample after the next rising edge.
  task automatic access(input bit wr, input bit wd, input int addr,
                        input logic [31:0] data, input bit sec, input bit dis,
                        input string req);
    int nStored = 0;
    bit ns = !sec && !dis;
    logic [31:0] expRd = '0;
    for (int l = 0; l < 4; l++) begin
      int id = addr + l;
      if ((l == 0 || wd) && idOk(id) && visible(id, sec, dis))
        expRd[8*l +: 8] = ns ? {model[id][6:0], 1'b0} : model[id];
    end
    reqValid = 1'b1; reqWrite = wr; reqWord = wd; reqAddr = ADDR_W'(addr);
    reqWdata = data; reqSecure = sec; secDisable = dis;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (wr) begin
      if (!wd || (idOk(addr) && idOk(addr + 3))) begin
        for (int l = 0; l < 4; l++) begin
          int id = addr + l;
          if ((l == 0 || wd) && idOk(id) && visible(id, sec, dis)) begin
            model[id] = ns ? {1'b1, data[8*l+1 +: 7]} : data[8*l +: 8];
            nStored++;
          end
        end
      end
      check({req, " R9 strobe"}, updStrobe, nStored > 0);
      if (nStored > 0) begin
        check({req, " R9 first"}, updFirst, addr);
        check({req, " R9 count"}, updCount, wd ? 4 : 1);
      end
    end else begin
      check({req, " rdValid"}, rdValid, 1);
      check(req, rdData, expRd);
    end
  endtask

  task automatic readAllBytes(input bit sec, input bit dis, input string req);
    for (int a = 0; a < SPAN; a++)
      access(0, 0, a, 0, sec, dis, idOk(a) ? req : "R8 read");
  endtask

  initial begin
    for (int i = 0; i < NUM_IDS; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1 strobe", updStrobe, 0);
    check("R1 rdValid", rdValid, 0);
    check("R1 array", prioFlat, '0);
    readAllBytes(1, 0, "R1 read");

    // R2 and R8: secure byte writes at every address, then secure read-back
    for (int a = 0; a < SPAN; a++)
      access(1, 0, a, 32'(8'(a * 37 + 5)), 1, 0, idOk(a) ? "R2 write" : "R8 write");
    readAllBytes(1, 0, "R2 read");

    // R3, R4, R5: non-secure view with a mixed group pattern
    groupBits = 48'hA5C3_0F96_5A3C;
    readAllBytes(0, 0, "R4 ns read");
    for (int a = 0; a < SPAN; a++)
      access(1, 0, a, 32'(8'(a * 11 + 200)), 0, 0,
             (idOk(a) && !groupBits[a]) ? "R3 ns write" : "R5 ns write");
    readAllBytes(1, 0, "R5 secure view");
    readAllBytes(0, 0, "R3 ns view");

    // R10: with security disabled, non-secure accesses are full-view
    for (int a = FIRST_SHARED; a < NUM_IDS; a++)
      access(1, 0, a, 32'(8'(a * 3 + 1)), 0, 1, "R10 write");
    readAllBytes(0, 1, "R10 read");

    // R6, R7: word writes and reads at every address, both views
    for (int a = 0; a < SPAN; a++)
      access(1, 1, a, 32'h0102_0304 * 32'(a + 1), 1, 0,
             (idOk(a) && idOk(a + 3)) ? "R6 word write" : "R7 word write");
    for (int a = 0; a < SPAN; a++)
      access(0, 1, a, 0, 1, 0, "R6 word read");
    for (int a = 0; a < SPAN; a++)
      access(1, 1, a, 32'hF00D_BEEF ^ 32'(a * 977), 0, 0,
             (idOk(a) && idOk(a + 3)) ? "R6 ns word write" : "R7 ns word write");
    for (int a = 0; a < SPAN; a++)
      access(0, 1, a, 0, 0, 0, "R6 ns word read");
    for (int i = 0; i < NUM_IDS; i++)
      check("R6 array", prioFlat[8*i +: 8], model[i]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule